// File: doc/BRIEF.md
# Exception Vector and Cause Generator

This block turns an exception event into the values a processor core needs to enter its handler. These values are the handler entry address, the saved return address, the 5-bit exception code and the branch-delay flag. It also sets the exception-level bit. The core presents an event kind together with the faulting PC, a delay-slot flag, the current exception-level and boot-vector status bits, the exception base register, and the interrupt vectoring controls. The interrupt vectoring controls are the vectoring enable, a spacing value, and the pending and mask lines.

A request is a one-cycle pulse on `req_i`. On the clock edge that samples it, every result is captured in registers. `ack_o` and the results are valid in the following cycle and hold until the next request. The handler address is built from a base and an offset. The base is either a fixed boot region or the exception base register aligned to 1 KiB. The offset depends on the event class: general, TLB refill, vectored interrupt or cache error. A second exception taken while the exception level is already set updates the code and the handler address. It leaves the saved return address and the delay-slot flag untouched.

Top module: `exc_vector_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the first request, `ack_o`, `handler_pc_o`, `epc_o`, `code_o`, `bd_o` and `exl_o` are all zero.
- R2: `ack_o` is high in exactly the cycle after each cycle in which `req_i` is high. In a cycle after one with `req_i` low, all result outputs keep their values.
- R3: `type_i` selects the event, and `code_o` gets its code:
  - interrupt 16 gives 0; TLB modify 11 gives 1; TLB load 9 gives 2; TLB store 10 gives 3.
  - address error on load 7 gives 4; address error on store 8 gives 5.
  - instruction bus error 14 gives 6; data bus error 15 gives 7.
  - syscall 0 gives 8; break 1 gives 9; reserved instruction 4 gives 10; coprocessor unusable 5 gives 11.
  - overflow 3 gives 12; trap 2 gives 13; floating point 6 gives 15.
  - read inhibit 12 gives 19; execute inhibit 13 gives 20; cache error 17 gives 30.
- R4: The base is `BOOT_BASE`+0x200 (default 0xBFC00200) when `bev_i` is 1. Otherwise it is `ebase_i` with bits 9:0 cleared. An event with no special offset enters at base+0x180.
- R5: A TLB load (9) or store (10) with `tlb_miss_i`=1 and `exl_i`=0 enters at base+0x000. With `exl_i`=1 or `tlb_miss_i`=0, it enters at base+0x180.
- R6: An interrupt (16) with `iv_i`=0 enters at base+0x180. With `iv_i`=1 and either `bev_i`=1 or `spacing_i`=0, it enters at base+0x200.
- R7: An interrupt with `iv_i`=1, `bev_i`=0 and a nonzero spacing enters at base+0x200+v*`spacing_i`*32. Here v is the index of the highest set bit of `pend_i & imask_i`, or 0 when that is empty.
- R8: A cache error (17) ignores `ebase_i`. It enters at `BOOT_BASE`+0x100 (0xBFC00100) when `bev_i` is 1, and at `CERR_BASE`+0x100 (0xA0000100) otherwise.
- R9: A request with `exl_i`=0 stores `pc_i` (minus 4 when `in_dslot_i` is 1) into `epc_o` and `in_dslot_i` into `bd_o`. Every request sets `exl_o`.
- R10: A request with `exl_i`=1 leaves `epc_o` and `bd_o` unchanged but still updates `code_o` and `handler_pc_o`.
- R11: Unused `type_i` values 18 to 31 give code 10 and enter at base+0x180.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Exception request pulse |
| type_i | input | 5 | Event kind (see R3) |
| pc_i | input | AW | Faulting instruction address |
| in_dslot_i | input | 1 | Fault lies in a branch delay slot |
| exl_i | input | 1 | Exception level already set |
| bev_i | input | 1 | Boot vectors selected |
| ebase_i | input | AW | Exception base register |
| iv_i | input | 1 | Interrupt vectoring enable |
| spacing_i | input | SPW | Interrupt vector spacing in 32-byte units |
| pend_i | input | NIRQ | Pending interrupt lines |
| imask_i | input | NIRQ | Interrupt enable mask |
| tlb_miss_i | input | 1 | Translation found no matching entry |
| ack_o | output | 1 | Results valid |
| handler_pc_o | output | AW | Handler entry address |
| epc_o | output | AW | Saved return address |
| code_o | output | 5 | Exception code |
| bd_o | output | 1 | Saved delay-slot flag |
| exl_o | output | 1 | Exception level after the event |

## Verification
The assertions take for granted that the request inputs are stable and meaningful in the cycle where `req_i` is high. They also take for granted that `pc_i` is word aligned, so that subtracting the delay-slot distance never wraps. The stimulus pulses `req_i` for one cycle at a time and drives every input away from the clock edge. It masks the random PCs to word alignment and keeps them away from zero. It mixes random kinds, including unused ones, with random exception-level, boot and miss bits. Idle gaps of random length between requests exercise the hold behaviour.

// File: rtl/exc_vec_pkg.sv
package exc_vec_pkg;

   typedef enum logic [4:0] {
      EK_SYSCALL = 5'd0,
      EK_BREAK   = 5'd1,
      EK_TRAP    = 5'd2,
      EK_OVFL    = 5'd3,
      EK_RESV    = 5'd4,
      EK_COPU    = 5'd5,
      EK_FPE     = 5'd6,
      EK_ADEL    = 5'd7,
      EK_ADES    = 5'd8,
      EK_TLBL    = 5'd9,
      EK_TLBS    = 5'd10,
      EK_TLBMOD  = 5'd11,
      EK_RDINH   = 5'd12,
      EK_XINH    = 5'd13,
      EK_IBUS    = 5'd14,
      EK_DBUS    = 5'd15,
      EK_IRQ     = 5'd16,
      EK_CERR    = 5'd17
   } exc_kind_e;

   typedef enum logic [1:0] {
      VC_GENERAL,
      VC_REFILL,
      VC_IRQ,
      VC_CACHE
   } vec_class_e;

   typedef struct packed {
      logic [4:0] code;
      logic       tlb_ls;
      logic       irq;
      logic       cerr;
   } kind_info_t;

   localparam logic [4:0] XC_INT    = 5'd0;
   localparam logic [4:0] XC_MOD    = 5'd1;
   localparam logic [4:0] XC_TLBL   = 5'd2;
   localparam logic [4:0] XC_TLBS   = 5'd3;
   localparam logic [4:0] XC_ADEL   = 5'd4;
   localparam logic [4:0] XC_ADES   = 5'd5;
   localparam logic [4:0] XC_IBE    = 5'd6;
   localparam logic [4:0] XC_DBE    = 5'd7;
   localparam logic [4:0] XC_SYS    = 5'd8;
   localparam logic [4:0] XC_BP     = 5'd9;
   localparam logic [4:0] XC_RI     = 5'd10;
   localparam logic [4:0] XC_CPU    = 5'd11;
   localparam logic [4:0] XC_OV     = 5'd12;
   localparam logic [4:0] XC_TR     = 5'd13;
   localparam logic [4:0] XC_FPE    = 5'd15;
   localparam logic [4:0] XC_RDINH  = 5'd19;
   localparam logic [4:0] XC_XINH   = 5'd20;
   localparam logic [4:0] XC_CACHE  = 5'd30;

   localparam int unsigned OFF_GENERAL = 32'h180;
   localparam int unsigned OFF_REFILL  = 32'h000;
   localparam int unsigned OFF_IRQ     = 32'h200;
   localparam int unsigned OFF_CACHE   = 32'h100;
   localparam int unsigned OFF_BOOT    = 32'h200;

endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
   import exc_vec_pkg::*;
(
   input  logic [4:0] kind_i,
   output kind_info_t info_o
);

   always_comb begin
      info_o        = '0;
      info_o.code   = XC_RI;
      unique case (kind_i)
         EK_SYSCALL: info_o.code = XC_SYS;
         EK_BREAK:   info_o.code = XC_BP;
         EK_TRAP:    info_o.code = XC_TR;
         EK_OVFL:    info_o.code = XC_OV;
         EK_RESV:    info_o.code = XC_RI;
         EK_COPU:    info_o.code = XC_CPU;
         EK_FPE:     info_o.code = XC_FPE;
         EK_ADEL:    info_o.code = XC_ADEL;
         EK_ADES:    info_o.code = XC_ADES;
         EK_TLBL: begin
            info_o.code   = XC_TLBL;
            info_o.tlb_ls = 1'b1;
         end
         EK_TLBS: begin
            info_o.code   = XC_TLBS;
            info_o.tlb_ls = 1'b1;
         end
         EK_TLBMOD:  info_o.code = XC_MOD;
         EK_RDINH:   info_o.code = XC_RDINH;
         EK_XINH:    info_o.code = XC_XINH;
         EK_IBUS:    info_o.code = XC_IBE;
         EK_DBUS:    info_o.code = XC_DBE;
         EK_IRQ: begin
            info_o.code = XC_INT;
            info_o.irq  = 1'b1;
         end
         EK_CERR: begin
            info_o.code = XC_CACHE;
            info_o.cerr = 1'b1;
         end
         default:    info_o.code = XC_RI;
      endcase
   end

endmodule

// File: rtl/exc_irq_offset.sv
module exc_irq_offset
   import exc_vec_pkg::*;
#(
   parameter int NIRQ = 8,
   parameter int SPW  = 5,
   parameter int OFFW = 16
) (
   input  logic [NIRQ-1:0] pend_i,
   input  logic [NIRQ-1:0] mask_i,
   input  logic [SPW-1:0]  spacing_i,
   input  logic            bev_i,
   output logic [OFFW-1:0] off_o
);

   localparam int unsigned STEP_SHIFT = 5;
   localparam int unsigned MAX_OFF    = OFF_IRQ + (NIRQ - 1) * (((1 << SPW) - 1) << STEP_SHIFT);
   localparam logic [OFFW-1:0] BASE_OFF = OFFW'(OFF_IRQ);

   if (NIRQ < 1) begin : g_bad_nirq
      $error("exc_irq_offset: NIRQ must be at least 1");
   end
   if (MAX_OFF >= (1 << OFFW)) begin : g_bad_offw
      $error("exc_irq_offset: OFFW too small for largest vector offset");
   end

   logic [NIRQ-1:0] active;
   logic [OFFW-1:0] stride;
   logic [OFFW-1:0] cand [NIRQ];
   logic [OFFW-1:0] picked;

   assign active = pend_i & mask_i;
   assign stride = OFFW'({spacing_i, {STEP_SHIFT{1'b0}}});

   for (genvar gi = 0; gi < NIRQ; gi++) begin : g_line
      assign cand[gi] = BASE_OFF + OFFW'(gi) * stride;
   end

   always_comb begin
      picked = BASE_OFF;
      for (int i = 0; i < NIRQ; i++) begin
         if (active[i]) picked = cand[i];
      end
   end

   assign off_o = (bev_i || (spacing_i == '0)) ? BASE_OFF : picked;

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
   import exc_vec_pkg::*;
#(
   parameter int              AW        = 32,
   parameter int              OFFW      = 16,
   parameter int              EBASE_LSB = 10,
   parameter logic [AW-1:0]   BOOT_BASE = 32'hBFC0_0000,
   parameter logic [AW-1:0]   CERR_BASE = 32'hA000_0000
) (
   input  kind_info_t      info_i,
   input  logic            exl_i,
   input  logic            bev_i,
   input  logic            iv_i,
   input  logic            tlb_miss_i,
   input  logic [AW-1:0]   ebase_i,
   input  logic [OFFW-1:0] irq_off_i,
   output logic [AW-1:0]   pc_o
);

   localparam logic [AW-1:0] BOOT_VEC   = BOOT_BASE + AW'(OFF_BOOT);
   localparam logic [AW-1:0] EBASE_MASK = ~((AW'(1) << EBASE_LSB) - AW'(1));
   localparam logic [AW-1:0] CERR_BOOT  = BOOT_BASE + AW'(OFF_CACHE);
   localparam logic [AW-1:0] CERR_ALT   = CERR_BASE + AW'(OFF_CACHE);

   vec_class_e      vclass;
   logic [AW-1:0]   base;
   logic [OFFW-1:0] off;

   always_comb begin
      if (info_i.cerr)                           vclass = VC_CACHE;
      else if (info_i.irq && iv_i)               vclass = VC_IRQ;
      else if (info_i.tlb_ls && tlb_miss_i && !exl_i) vclass = VC_REFILL;
      else                                       vclass = VC_GENERAL;
   end

   always_comb begin
      unique case (vclass)
         VC_REFILL: off = OFFW'(OFF_REFILL);
         VC_IRQ:    off = irq_off_i;
         default:   off = OFFW'(OFF_GENERAL);
      endcase
   end

   assign base = bev_i ? BOOT_VEC : (ebase_i & EBASE_MASK);

   always_comb begin
      if (vclass == VC_CACHE) pc_o = bev_i ? CERR_BOOT : CERR_ALT;
      else                    pc_o = base + AW'(off);
   end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
   import exc_vec_pkg::*;
#(
   parameter int            AW          = 32,
   parameter int            NIRQ        = 8,
   parameter int            SPW         = 5,
   parameter int            OFFW        = 16,
   parameter int            EBASE_LSB   = 10,
   parameter int            DSLOT_BYTES = 4,
   parameter logic [AW-1:0] BOOT_BASE   = 32'hBFC0_0000,
   parameter logic [AW-1:0] CERR_BASE   = 32'hA000_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  logic [4:0]      type_i,
   input  logic [AW-1:0]   pc_i,
   input  logic            in_dslot_i,
   input  logic            exl_i,
   input  logic            bev_i,
   input  logic [AW-1:0]   ebase_i,
   input  logic            iv_i,
   input  logic [SPW-1:0]  spacing_i,
   input  logic [NIRQ-1:0] pend_i,
   input  logic [NIRQ-1:0] imask_i,
   input  logic            tlb_miss_i,
   output logic            ack_o,
   output logic [AW-1:0]   handler_pc_o,
   output logic [AW-1:0]   epc_o,
   output logic [4:0]      code_o,
   output logic            bd_o,
   output logic            exl_o
);

   if (OFFW >= AW) begin : g_bad_offw
      $error("exc_vector_gen: OFFW must be narrower than AW");
   end
   if (EBASE_LSB < 10 || EBASE_LSB >= AW) begin : g_bad_align
      $error("exc_vector_gen: EBASE_LSB out of range");
   end

   kind_info_t      info;
   logic [OFFW-1:0] irq_off;
   logic [AW-1:0]   target_pc;
   logic [AW-1:0]   ret_pc;

   exc_code_map u_map (
      .kind_i (type_i),
      .info_o (info)
   );

   exc_irq_offset #(
      .NIRQ (NIRQ),
      .SPW  (SPW),
      .OFFW (OFFW)
   ) u_irq (
      .pend_i    (pend_i),
      .mask_i    (imask_i),
      .spacing_i (spacing_i),
      .bev_i     (bev_i),
      .off_o     (irq_off)
   );

   exc_target_calc #(
      .AW        (AW),
      .OFFW      (OFFW),
      .EBASE_LSB (EBASE_LSB),
      .BOOT_BASE (BOOT_BASE),
      .CERR_BASE (CERR_BASE)
   ) u_tgt (
      .info_i     (info),
      .exl_i      (exl_i),
      .bev_i      (bev_i),
      .iv_i       (iv_i),
      .tlb_miss_i (tlb_miss_i),
      .ebase_i    (ebase_i),
      .irq_off_i  (irq_off),
      .pc_o       (target_pc)
   );

   assign ret_pc = in_dslot_i ? (pc_i - AW'(DSLOT_BYTES)) : pc_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_o        <= 1'b0;
         handler_pc_o <= '0;
         epc_o        <= '0;
         code_o       <= '0;
         bd_o         <= 1'b0;
         exl_o        <= 1'b0;
      end else begin
         ack_o <= req_i;
         if (req_i) begin
            handler_pc_o <= target_pc;
            code_o       <= info.code;
            exl_o        <= 1'b1;
            if (!exl_i) begin
               epc_o <= ret_pc;
               bd_o  <= in_dslot_i;
            end
         end
      end
   end

endmodule

// File: rtl/exc_vector_chk.sv
module exc_vector_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_i,
   input logic [4:0]    type_i,
   input logic [AW-1:0] pc_i,
   input logic          in_dslot_i,
   input logic          exl_i,
   input logic          bev_i,
   input logic          tlb_miss_i,
   input logic          ack_o,
   input logic [AW-1:0] handler_pc_o,
   input logic [AW-1:0] epc_o,
   input logic [4:0]    code_o,
   input logic          bd_o,
   input logic          exl_o
);

   p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> ack_o);

   p_no_stray_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> !ack_o);

   p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !req_i |=> ($stable(handler_pc_o) && $stable(code_o) && $stable(epc_o)
                  && $stable(bd_o) && $stable(exl_o)));

   p_exl_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_i |=> exl_o);

   p_epc_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !exl_i) |=>
         (epc_o == ($past(pc_i) - ($past(in_dslot_i) ? AW'(4) : AW'(0)))
          && bd_o == $past(in_dslot_i)));

   p_epc_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && exl_i) |=> ($stable(epc_o) && $stable(bd_o)));

   p_refill_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && (type_i == 5'd9 || type_i == 5'd10) && tlb_miss_i && !exl_i && !bev_i)
         |=> (handler_pc_o[9:0] == 10'd0));

   p_cache_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && type_i == 5'd17) |=> (code_o == 5'd30));

endmodule

bind exc_vector_gen exc_vector_chk #(.AW(AW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_i        (req_i),
   .type_i       (type_i),
   .pc_i         (pc_i),
   .in_dslot_i   (in_dslot_i),
   .exl_i        (exl_i),
   .bev_i        (bev_i),
   .tlb_miss_i   (tlb_miss_i),
   .ack_o        (ack_o),
   .handler_pc_o (handler_pc_o),
   .epc_o        (epc_o),
   .code_o       (code_o),
   .bd_o         (bd_o),
   .exl_o        (exl_o)
);

// File: tb/sim_exc_vector_gen.sv
module sim_exc_vector_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [4:0]  type_i = '0;
   logic [31:0] pc_i = '0;
   logic        in_dslot_i = 1'b0;
   logic        exl_i = 1'b0;
   logic        bev_i = 1'b0;
   logic [31:0] ebase_i = '0;
   logic        iv_i = 1'b0;
   logic [4:0]  spacing_i = '0;
   logic [7:0]  pend_i = '0;
   logic [7:0]  imask_i = '0;
   logic        tlb_miss_i = 1'b0;
   logic        ack_o;
   logic [31:0] handler_pc_o;
   logic [31:0] epc_o;
   logic [4:0]  code_o;
   logic        bd_o;
   logic        exl_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] m_pc, m_epc;
   logic [4:0]  m_code;
   logic        m_bd, m_exl;

   always #4 clk = ~clk;

   exc_vector_gen u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .type_i(type_i), .pc_i(pc_i),
      .in_dslot_i(in_dslot_i), .exl_i(exl_i), .bev_i(bev_i), .ebase_i(ebase_i),
      .iv_i(iv_i), .spacing_i(spacing_i), .pend_i(pend_i), .imask_i(imask_i),
      .tlb_miss_i(tlb_miss_i), .ack_o(ack_o), .handler_pc_o(handler_pc_o),
      .epc_o(epc_o), .code_o(code_o), .bd_o(bd_o), .exl_o(exl_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [4:0] exp_code(input logic [4:0] k);
      case (k)
         5'd0:  return 5'd8;
         5'd1:  return 5'd9;
         5'd2:  return 5'd13;
         5'd3:  return 5'd12;
         5'd4:  return 5'd10;
         5'd5:  return 5'd11;
         5'd6:  return 5'd15;
         5'd7:  return 5'd4;
         5'd8:  return 5'd5;
         5'd9:  return 5'd2;
         5'd10: return 5'd3;
         5'd11: return 5'd1;
         5'd12: return 5'd19;
         5'd13: return 5'd20;
         5'd14: return 5'd6;
         5'd15: return 5'd7;
         5'd16: return 5'd0;
         5'd17: return 5'd30;
         default: return 5'd10;
      endcase
   endfunction

   function automatic logic [31:0] exp_pc(input logic [4:0] k, input logic exl, input logic bev,
                                          input logic [31:0] eb, input logic iv, input logic [4:0] sp,
                                          input logic [7:0] pend, input logic [7:0] mask, input logic miss);
      logic [31:0] base, off;
      int v;
      logic [7:0] act;
      if (k == 5'd17) return bev ? 32'hBFC0_0100 : 32'hA000_0100;
      base = bev ? 32'hBFC0_0200 : (eb & 32'hFFFF_FC00);
      off  = 32'h180;
      if ((k == 5'd9 || k == 5'd10) && miss && !exl) off = 32'h0;
      else if (k == 5'd16 && iv) begin
         if (bev || sp == 5'd0) off = 32'h200;
         else begin
            v = 0;
            act = pend & mask;
            for (int i = 0; i < 8; i++) if (act[i]) v = i;
            off = 32'h200 + 32'(v) * 32'(sp) * 32'd32;
         end
      end
      return base + off;
   endfunction

   task automatic do_req(input logic [4:0] k, input logic [31:0] pc, input logic ds, input logic exl,
                         input logic bev, input logic [31:0] eb, input logic iv, input logic [4:0] sp,
                         input logic [7:0] pend, input logic [7:0] mask, input logic miss);
      @(negedge clk);
      type_i = k; pc_i = pc; in_dslot_i = ds; exl_i = exl; bev_i = bev; ebase_i = eb;
      iv_i = iv; spacing_i = sp; pend_i = pend; imask_i = mask; tlb_miss_i = miss;
      req_i = 1'b1;
      m_pc   = exp_pc(k, exl, bev, eb, iv, sp, pend, mask, miss);
      m_code = exp_code(k);
      m_exl  = 1'b1;
      if (!exl) begin
         m_epc = ds ? pc - 32'd4 : pc;
         m_bd  = ds;
      end
      @(negedge clk);
      req_i = 1'b0;
      chk(ack_o == 1'b1, "R2 ack", 32'(ack_o), 32'd1);
      chk(handler_pc_o == m_pc, "R4 R5 R6 R7 R8 handler", handler_pc_o, m_pc);
      chk(code_o == m_code, "R3 R11 code", 32'(code_o), 32'(m_code));
      chk(epc_o == m_epc, "R9 R10 epc", epc_o, m_epc);
      chk(bd_o == m_bd, "R9 R10 bd", 32'(bd_o), 32'(m_bd));
      chk(exl_o == m_exl, "R9 exl", 32'(exl_o), 32'(m_exl));
   endtask

   task automatic idle_check();
      @(negedge clk);
      chk(ack_o == 1'b0, "R2 idle ack", 32'(ack_o), 32'd0);
      chk(handler_pc_o == m_pc && code_o == m_code && epc_o == m_epc && bd_o == m_bd,
          "R2 hold", handler_pc_o, m_pc);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      m_pc = '0; m_epc = '0; m_code = '0; m_bd = 1'b0; m_exl = 1'b0;
      repeat (3) @(negedge clk);
      chk(ack_o == 1'b0 && handler_pc_o == 32'd0 && epc_o == 32'd0, "R1 reset", handler_pc_o, 32'd0);
      chk(code_o == 5'd0 && bd_o == 1'b0 && exl_o == 1'b0, "R1 reset flags", 32'(code_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ack_o == 1'b0 && handler_pc_o == 32'd0 && exl_o == 1'b0, "R1 after release", handler_pc_o, 32'd0);

      // R4 general vector, both bases
      do_req(5'd0, 32'h0040_1000, 1'b0, 1'b0, 1'b0, 32'h8000_1234, 1'b0, 5'd0, 8'h00, 8'h00, 1'b0);
      chk(handler_pc_o == 32'h8000_1180, "R4 ebase", handler_pc_o, 32'h8000_1180);
      do_req(5'd1, 32'h0040_2000, 1'b0, 1'b0, 1'b1, 32'h8000_1234, 1'b0, 5'd0, 8'h00, 8'h00, 1'b0);
      chk(handler_pc_o == 32'hBFC0_0380, "R4 boot", handler_pc_o, 32'hBFC0_0380);
      idle_check();
      // R5 refill vs late miss
      do_req(5'd9, 32'h0040_3000, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 5'd0, 8'h00, 8'h00, 1'b1);
      chk(handler_pc_o == 32'h8000_0000, "R5 refill", handler_pc_o, 32'h8000_0000);
      do_req(5'd10, 32'h0040_4000, 1'b1, 1'b1, 1'b0, 32'h8000_0000, 1'b0, 5'd0, 8'h00, 8'h00, 1'b1);
      chk(handler_pc_o == 32'h8000_0180, "R5 miss with exl", handler_pc_o, 32'h8000_0180);
      chk(epc_o == 32'h0040_3000 && bd_o == 1'b0, "R10 frozen epc", epc_o, 32'h0040_3000);
      chk(code_o == 5'd3, "R10 code updated", 32'(code_o), 32'd3);
      // R6 interrupts
      do_req(5'd16, 32'h100, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 5'd4, 8'hFF, 8'hFF, 1'b0);
      chk(handler_pc_o == 32'h8000_0180, "R6 iv off", handler_pc_o, 32'h8000_0180);
      do_req(5'd16, 32'h100, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 5'd0, 8'hFF, 8'hFF, 1'b0);
      chk(handler_pc_o == 32'h8000_0200, "R6 zero spacing", handler_pc_o, 32'h8000_0200);
      do_req(5'd16, 32'h100, 1'b0, 1'b0, 1'b1, 32'h8000_0000, 1'b1, 5'd3, 8'hFF, 8'hFF, 1'b0);
      chk(handler_pc_o == 32'hBFC0_0400, "R6 boot", handler_pc_o, 32'hBFC0_0400);
      // R7 vectored
      do_req(5'd16, 32'h100, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 5'd1, 8'hA5, 8'h0F, 1'b0);
      chk(handler_pc_o == 32'h8000_0240, "R7 vector 2", handler_pc_o, 32'h8000_0240);
      do_req(5'd16, 32'h100, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 5'd31, 8'h80, 8'hFF, 1'b0);
      chk(handler_pc_o == 32'h8000_1D20, "R7 top line", handler_pc_o, 32'h8000_1D20);
      do_req(5'd16, 32'h100, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 5'd2, 8'hF0, 8'h0F, 1'b0);
      chk(handler_pc_o == 32'h8000_0200, "R7 none enabled", handler_pc_o, 32'h8000_0200);
      // R8 cache error
      do_req(5'd17, 32'h200, 1'b0, 1'b0, 1'b0, 32'h8123_4000, 1'b0, 5'd0, 8'h00, 8'h00, 1'b0);
      chk(handler_pc_o == 32'hA000_0100, "R8 alt base", handler_pc_o, 32'hA000_0100);
      do_req(5'd17, 32'h200, 1'b0, 1'b0, 1'b1, 32'h8123_4000, 1'b0, 5'd0, 8'h00, 8'h00, 1'b0);
      chk(handler_pc_o == 32'hBFC0_0100, "R8 boot", handler_pc_o, 32'hBFC0_0100);
      // R9 delay slot
      do_req(5'd7, 32'h0000_0400, 1'b1, 1'b0, 1'b0, 32'h8000_0000, 1'b0, 5'd0, 8'h00, 8'h00, 1'b0);
      chk(epc_o == 32'h0000_03FC && bd_o == 1'b1, "R9 dslot", epc_o, 32'h0000_03FC);
      // R11 unused kind
      do_req(5'd25, 32'h0000_0800, 1'b0, 1'b0, 1'b0, 32'h8000_0000, 1'b1, 5'd1, 8'hFF, 8'hFF, 1'b1);
      chk(code_o == 5'd10 && handler_pc_o == 32'h8000_0180, "R11 unused", 32'(code_o), 32'd10);
      idle_check();

      for (int n = 0; n < 400; n++) begin
         logic [4:0] k;
         k = ($urandom % 6 == 0) ? 5'($urandom % 32) : 5'($urandom % 18);
         do_req(k, ($urandom & 32'hFFFF_FFFC) | 32'h10, 1'($urandom % 2), ($urandom % 3 == 0),
                ($urandom % 4 == 0), $urandom, 1'($urandom % 2), 5'($urandom % 32),
                8'($urandom), 8'($urandom), 1'($urandom % 2));
         for (int g = 0; g < int'($urandom % 3); g++) idle_check();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule